// File: doc/BRIEF.md
# Memory-to-Stream DMA Channel

This block is a single-channel copy engine that fetches a contiguous buffer from a memory port one 32-bit word at a time and hands each word out on a ready/valid stream, flagging the final word. Software sets it up through a four-entry register slave: a control word with a run/stop bit and two interrupt enables, a source address, a byte count and a status word.

Writing the byte count is what launches the transfer. The control and source registers may be written in any order beforehand. The count write is accepted only when the channel is running, idle and the count is a nonzero multiple of four. Any other count write is dropped and flagged as an error. Completion and error are sticky status bits that software clears by writing 1. The interrupt line is the OR of each status bit that has its enable set.

Top module: `mm2s_dma`

## Requirements
- R1: Register index 0 is control, with bit0 as run/stop, bit1 as the completion interrupt enable and bit2 as the error interrupt enable. Its readback returns those three bits, and the upper bits read 0. Index 1 (source address) reads back the full written value. Index 2 (byte count, LEN_W bits) reads back the value last written to it.
- R2: A write to index 2 is accepted when run is 1, the channel is idle, and the value is nonzero with bits [1:0] equal to 0. At the clock edge of that write, status bit0 (busy) becomes 1, mem_req asserts, and mem_addr equals the source address.
- R3: A count write while run is 0 starts nothing (busy stays 0 and mem_req stays 0) and sets status bit2 (error).
- R4: A count write while busy does not alter the running transfer, whose number of beats stays unchanged, and it sets the error bit.
- R5: A count of zero, or one with bits [1:0] not both 0, starts nothing and sets the error bit.
- R6: Word k of a transfer is read from source + 4k. Only one read is outstanding at a time: after a request is accepted (mem_req and mem_ready), mem_req stays low until the response word has been delivered on the stream. A request that has not been accepted holds its address.
- R7: The returned words appear on st_data in order. While st_valid is high and st_ready is low, st_valid, st_data and st_last hold. st_last is high exactly on the final word.
- R8: At the edge where the final word is accepted, busy clears and status bit1 (done) sets. Done and error stay set until a 1 is written to their bit of status (index 3). Writing 0 to those bits has no effect.
- R9: irq equals (done AND completion enable) OR (error AND error enable) in every cycle.
- R10: After reset, all registers read 0, and irq, st_valid and mem_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register selected by reg_idx |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Read request byte address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of the transfer |
| st_ready | input | 1 | Stream sink accepts the word |

## Verification
Register effects land at the edge of the write, so the bench reads status, mem_req and mem_addr on the falling edge right after a write strobe. Each stream beat is scored on the falling edge before the rising edge that accepts it, when the bench has just chosen st_ready and st_valid is settled. Done, busy and irq are compared on the falling edge after the final beat's accepting edge, and irq is also compared within the same cycle as the status bits it derives from. Memory responses arrive one cycle after acceptance, and both ready inputs are randomized with a fixed seed.

// File: rtl/mm2s_dma_pkg.sv
package mm2s_dma_pkg;

    localparam int REG_DATA_W = 32;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_SRC  = 2'd1,
        REG_LEN  = 2'd2,
        REG_STAT = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic err_ie;
        logic done_ie;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic err;
        logic done;
    } stat_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_REQ,
        ENG_WAIT,
        ENG_SEND
    } eng_state_e;

    function automatic logic word_aligned(input logic [1:0] lsb);
        return lsb == 2'b00;
    endfunction

endpackage

// File: rtl/mm2s_dma_regs.sv
module mm2s_dma_regs
    import mm2s_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wen,
    input  logic [1:0]              reg_idx,
    input  logic [REG_DATA_W-1:0]   reg_wdata,
    output logic [REG_DATA_W-1:0]   reg_rdata,
    input  logic                    busy,
    input  logic                    done_pulse,
    output logic                    start,
    output logic [ADDR_W-1:0]       start_addr,
    output logic [LEN_W-3:0]        start_words,
    output logic                    irq
);

    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [ADDR_W-1:0] src_q;
    logic [LEN_W-1:0]  len_q;

    reg_idx_e         idx;
    logic             wr_ctrl, wr_src, wr_len, wr_stat;
    logic [LEN_W-1:0] len_w;
    logic             len_ok;
    logic             err_set;

    assign idx     = reg_idx_e'(reg_idx);
    assign wr_ctrl = reg_wen && (idx == REG_CTRL);
    assign wr_src  = reg_wen && (idx == REG_SRC);
    assign wr_len  = reg_wen && (idx == REG_LEN);
    assign wr_stat = reg_wen && (idx == REG_STAT);

    assign len_w   = reg_wdata[LEN_W-1:0];
    assign len_ok  = ctrl_q.run && !busy && (len_w != '0) && word_aligned(len_w[1:0]);
    assign start   = wr_len && len_ok;
    assign err_set = wr_len && !len_ok;

    assign start_addr  = src_q;
    assign start_words = len_w[LEN_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            src_q  <= '0;
            len_q  <= '0;
            stat_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[2:0]);
            if (wr_src)  src_q  <= reg_wdata[ADDR_W-1:0];
            if (wr_len)  len_q  <= len_w;
            stat_q.done <= done_pulse || (stat_q.done && !(wr_stat && reg_wdata[1]));
            stat_q.err  <= err_set    || (stat_q.err  && !(wr_stat && reg_wdata[2]));
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (idx)
            REG_CTRL: reg_rdata = {{(REG_DATA_W-3){1'b0}}, ctrl_q};
            REG_SRC:  reg_rdata = REG_DATA_W'(src_q);
            REG_LEN:  reg_rdata = REG_DATA_W'(len_q);
            REG_STAT: reg_rdata = {{(REG_DATA_W-3){1'b0}}, stat_q, busy};
        endcase
    end

    assign irq = (stat_q.done && ctrl_q.done_ie) || (stat_q.err && ctrl_q.err_ie);

    // R3: count write with run cleared is flagged
    assert_stopped_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_len && !ctrl_q.run) |=> stat_q.err);

    // R4: count write during a transfer is flagged
    assert_busy_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_len && busy) |=> stat_q.err);

    // R8: engine completion lands in the sticky bit
    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> stat_q.done);

endmodule

// File: rtl/mm2s_dma_engine.sv
module mm2s_dma_engine
    import mm2s_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [LEN_W-3:0]      start_words,
    output logic                  busy,
    output logic                  done_pulse,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_ready,
    input  logic                  mem_rvalid,
    input  logic [REG_DATA_W-1:0] mem_rdata,
    output logic                  st_valid,
    output logic [REG_DATA_W-1:0] st_data,
    output logic                  st_last,
    input  logic                  st_ready
);

    localparam int CNT_W = LEN_W - 2;

    eng_state_e            state_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [CNT_W-1:0]      left_q;
    logic [REG_DATA_W-1:0] data_q;
    logic                  final_word;

    assign final_word = (left_q == CNT_W'(1));
    assign busy       = (state_q != ENG_IDLE);
    assign mem_req    = (state_q == ENG_REQ);
    assign mem_addr   = addr_q;
    assign st_valid   = (state_q == ENG_SEND);
    assign st_data    = data_q;
    assign st_last    = st_valid && final_word;
    assign done_pulse = st_valid && st_ready && final_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            data_q  <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: if (start) begin
                    addr_q  <= start_addr;
                    left_q  <= start_words;
                    state_q <= ENG_REQ;
                end
                ENG_REQ: if (mem_ready) state_q <= ENG_WAIT;
                ENG_WAIT: if (mem_rvalid) begin
                    data_q  <= mem_rdata;
                    state_q <= ENG_SEND;
                end
                ENG_SEND: if (st_ready) begin
                    if (final_word) begin
                        state_q <= ENG_IDLE;
                    end else begin
                        left_q  <= left_q - CNT_W'(1);
                        addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
                        state_q <= ENG_REQ;
                    end
                end
            endcase
        end
    end

    // R6: single outstanding read
    assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> !mem_req);

    // R6: unaccepted request holds
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R7: stalled beat holds
    assert_stream_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

    // R8: last accepted beat ends the transfer
    assert_last_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && st_last) |=> !busy);

endmodule

// File: rtl/mm2s_dma.sv
module mm2s_dma
    import mm2s_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wen,
    input  logic [1:0]            reg_idx,
    input  logic [REG_DATA_W-1:0] reg_wdata,
    output logic [REG_DATA_W-1:0] reg_rdata,
    output logic                  irq,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_ready,
    input  logic                  mem_rvalid,
    input  logic [REG_DATA_W-1:0] mem_rdata,
    output logic                  st_valid,
    output logic [REG_DATA_W-1:0] st_data,
    output logic                  st_last,
    input  logic                  st_ready
);

    logic              busy, done_pulse, start;
    logic [ADDR_W-1:0] start_addr;
    logic [LEN_W-3:0]  start_words;

    mm2s_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .reg_wen     (reg_wen),
        .reg_idx     (reg_idx),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy        (busy),
        .done_pulse  (done_pulse),
        .start       (start),
        .start_addr  (start_addr),
        .start_words (start_words),
        .irq         (irq)
    );

    mm2s_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_addr  (start_addr),
        .start_words (start_words),
        .busy        (busy),
        .done_pulse  (done_pulse),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ready   (mem_ready),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .st_valid    (st_valid),
        .st_data     (st_data),
        .st_last     (st_last),
        .st_ready    (st_ready)
    );

    // R10: nothing moves out of reset
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $past(rst) |-> (!st_valid && !mem_req && !irq));

endmodule

// File: tb/mm2s_dma_bench.sv
module mm2s_dma_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        st_valid;
    logic [31:0] st_data;
    logic        st_last;
    logic        st_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    int mem_dens = 2;
    int st_dens = 2;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    logic [31:0] exp_base = '0;
    int exp_n = 0;
    int beats = 0;
    bit reported = 0;

    always #10 clk = ~clk;

    mm2s_dma u_mm2s_dma (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready)
    );

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
        end
        $finish;
    endtask

    // memory model and stream sink; each beat is scored before its accepting edge
    always @(negedge clk) begin
        mem_rvalid = pend;
        mem_rdata  = pend ? memfn(pend_addr) : 32'h0;
        mem_ready  = rst ? 1'b0 : (($urandom % 4) < mem_dens);
        pend       = mem_req && mem_ready;
        pend_addr  = mem_addr;
        st_ready   = rst ? 1'b0 : (($urandom % 4) < st_dens);
        if (st_valid && st_ready) begin
            // R6 R7: word order, address stride and last flag
            chk(st_data == memfn(exp_base + 32'(4 * beats)), "R7", "beat data",
                st_data, memfn(exp_base + 32'(4 * beats)));
            chk(st_last == (beats == exp_n - 1), "R7", "last flag",
                32'(st_last), 32'(beats == exp_n - 1));
            beats++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic wr(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk);
        reg_idx = i; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [1:0] i, output logic [31:0] d);
        reg_idx = i;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rd(2'd3, s);
        while (s[0]) begin
            @(negedge clk);
            rd(2'd3, s);
        end
    endtask

    task automatic transfer(input logic [31:0] src, input int n, input bit overwrite);
        logic [31:0] s;
        wr(2'd1, src);
        exp_base = src; exp_n = n; beats = 0;
        wr(2'd2, 32'(4 * n));
        rd(2'd3, s);
        chk(s[0] == 1'b1, "R2", "busy after count write", s, 32'h1);
        chk(mem_req == 1'b1 && mem_addr == src, "R2", "first request address", mem_addr, src);
        if (overwrite) begin
            wr(2'd2, 32'd64);
            rd(2'd3, s);
            chk(s[2] == 1'b1, "R4", "error after busy count write", s, 32'h4);
        end
        wait_idle();
        chk(beats == n, "R4", "beat count", 32'(beats), 32'(n));
        rd(2'd3, s);
        chk(s[1] == 1'b1, "R8", "done set", s, 32'h2);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v);
            chk(v == 32'h0, "R10", "register after reset", v, 32'h0);
        end
        chk(!irq && !st_valid && !mem_req, "R10", "outputs after reset",
            {29'h0, irq, st_valid, mem_req}, 32'h0);

        // R3: count write with run cleared
        wr(2'd2, 32'd16);
        rd(2'd3, v);
        chk(v == 32'h4, "R3", "status after stopped write", v, 32'h4);
        chk(!mem_req, "R3", "no request", 32'(mem_req), 32'h0);
        chk(!irq, "R9", "irq with error disabled", 32'(irq), 32'h0);
        wr(2'd0, 32'h4);
        chk(irq, "R9", "irq with error enabled", 32'(irq), 32'h1);
        wr(2'd3, 32'h2);
        rd(2'd3, v);
        chk(v[2] == 1'b1, "R8", "error ignores write of 0", v, 32'h4);
        wr(2'd3, 32'h4);
        rd(2'd3, v);
        chk(v == 32'h0, "R8", "error cleared by 1", v, 32'h0);
        chk(!irq, "R9", "irq drops", 32'(irq), 32'h0);

        // R1 readbacks
        wr(2'd0, 32'hFFFF_FFF9);
        rd(2'd0, v);
        chk(v == 32'h1, "R1", "control readback", v, 32'h1);
        wr(2'd1, 32'hDEAD_BEE0);
        rd(2'd1, v);
        chk(v == 32'hDEAD_BEE0, "R1", "source readback", v, 32'hDEAD_BEE0);

        // R5: bad counts
        wr(2'd2, 32'd6);
        rd(2'd3, v);
        chk(v == 32'h4, "R5", "unaligned count rejected", v, 32'h4);
        rd(2'd2, v);
        chk(v == 32'd6, "R1", "count readback", v, 32'd6);
        wr(2'd3, 32'h4);
        wr(2'd2, 32'd0);
        rd(2'd3, v);
        chk(v == 32'h4, "R5", "zero count rejected", v, 32'h4);
        wr(2'd3, 32'h4);

        // directed single-word transfer with completion interrupt
        wr(2'd0, 32'h3);
        transfer(32'h0000_1000, 1, 0);
        chk(irq, "R9", "irq on done", 32'(irq), 32'h1);
        wr(2'd3, 32'h2);
        rd(2'd3, v);
        chk(v == 32'h0, "R8", "done cleared", v, 32'h0);
        chk(!irq, "R9", "irq after clear", 32'(irq), 32'h0);

        // R4: count overwrite during slow transfer
        st_dens = 1;
        transfer(32'h0000_2000, 5, 1);
        wr(2'd3, 32'h6);

        // random transfers
        void'($urandom(32'd1234));
        for (int t = 0; t < 10; t++) begin
            mem_dens = 1 + ($urandom % 3);
            st_dens  = 1 + ($urandom % 3);
            transfer({$urandom} & 32'hFFFF_FFFC, 1 + ($urandom % 12), 0);
            wr(2'd3, 32'h6);
        end
        mem_dens = 4; st_dens = 4;
        transfer(32'hFFFF_FFF0, 8, 0);
        summary();
    end

endmodule